// File: doc/BRIEF.md
# Per-Processor Interrupt Acknowledge and End-of-Interrupt Unit

This block sits between an interrupt dispatcher and one processor. The dispatcher offers raise requests on a valid/ready stream. Each request carries a source index, a 4-bit priority, a vector and a sense flag (level or edge). The unit keeps two bitmaps of sources. One holds the sources that have been raised toward the processor and not yet taken. The other holds the sources the processor is servicing now. A combinational scan picks the strongest member of each bitmap. The unit drives a single interrupt request line from the results.

The processor reaches the unit through a small register port. The port has four registers, selected by `req_sel`: 0 is the task priority, 1 is the identity register, 2 is acknowledge and 3 is end-of-interrupt. Requests are accepted on `req_valid && req_ready`. A read returns its data one cycle later in a one-entry response register (`rsp_valid`, `rsp_data`). That register is emptied by `rsp_ready`. A new request is accepted only while that register is empty or being emptied in the same cycle (`req_ready = !rsp_valid || rsp_ready`). A response that is not taken holds its data unchanged. The raise stream is refused (`raise_ready` low) in any cycle in which a register request is accepted, so the two never act in the same cycle.

Top module: `cpu_irq_ack_unit`

## Requirements
- R1: An accepted raise whose priority is less than or equal to the task priority is dropped: it leaves the raised set and the request line unchanged.
- R2: An accepted raise for a source already in the raised set is a missed interrupt: its new priority and vector are discarded and nothing changes.
- R3: Each set selects the member with the strictly greatest priority. On equal priorities the lowest source index wins. An empty set selects nothing. A member's priority and vector are those of the last raise of that index that was kept.
- R4: An acknowledge read (select 2) clears `irq_out` on the following cycle. With an empty raised set it returns the spurious vector `SPUR_VEC`.
- R5: If the selected raised source is no longer active, or its priority no longer exceeds the task priority, the acknowledge clears its activity and returns `SPUR_VEC`. Otherwise the source joins the in-service set and its own vector is returned.
- R6: Every acknowledge that finds a source removes it from the raised set. An edge-sensitive source (`raise_level` = 0) also loses its activity.
- R7: A write to end-of-interrupt (select 3) retires the strongest in-service source, whatever data is written. A read of select 3 returns zero.
- R8: After an end-of-interrupt write, `irq_out` is set again if the raised set is non-empty and its best priority exceeds the best priority left in service, or if nothing is left in service.
- R9: The task priority register (select 0) stores the low 4 bits of a write and reads back zero-extended. Reset gives task priority 0xF, empty sets, `irq_out` low and no response pending.
- R10: A read of select 1 returns the parameter `CPU_ID`. Writes to selects 1 and 2 change no state.
- R11: A raise that is kept (priority above the task priority, source not already raised) sets `irq_out` on the following cycle.
- R12: `req_ready` equals `!rsp_valid || rsp_ready`. An unconsumed response keeps `rsp_valid` and `rsp_data` stable. `raise_ready` is low in any cycle in which a register request is accepted.
- R13: A bit set in `level_drop` clears the activity of that source. A later acknowledge that selects it returns `SPUR_VEC`. A raise kept in the same cycle sets activity again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| raise_valid | input | 1 | Raise request offered |
| raise_ready | output | 1 | Raise request can be taken this cycle |
| raise_idx | input | IDX_W | Source index of the raise |
| raise_prio | input | 4 | Source priority |
| raise_vec | input | VEC_W | Source vector |
| raise_level | input | 1 | 1 = level-sensitive, 0 = edge-sensitive |
| level_drop | input | NSRC | Per-source activity clear pulses |
| req_valid | input | 1 | Register request offered |
| req_ready | output | 1 | Register request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_sel | input | 2 | Register select: 0 task priority, 1 identity, 2 acknowledge, 3 end-of-interrupt |
| req_wdata | input | VEC_W | Write data |
| rsp_valid | output | 1 | Read data available |
| rsp_ready | input | 1 | Read data consumed |
| rsp_data | output | VEC_W | Read data |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the unit with 12 sources, which is not a power of two. With so few indices, random raises often hit an index that is already raised, and equal priorities occur often. That exercises the missed-interrupt path and the lowest-index tie rule many times over. `CPU_ID` is set to 5 and `SPUR_VEC` to 0x3C. These values differ from any reset value or default, so an identity read or a spurious acknowledge can be told apart from a stuck or zero output.

// File: rtl/cpu_irq_pkg.sv
package cpu_irq_pkg;
  localparam int PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  typedef enum logic [1:0] {
    SEL_TPRI = 2'd0,
    SEL_IDENT = 2'd1,
    SEL_ACK = 2'd2,
    SEL_EOI = 2'd3
  } reg_sel_e;

  localparam prio_t TPRI_RESET = 4'hF;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import cpu_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IDX_W = 5
) (
  input  logic [NSRC-1:0]        member,
  input  prio_t [NSRC-1:0]       prio,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output prio_t                  best
);
  // Linear scan; strict compare keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (member[i] && (!found || prio[i] > best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_src_store.sv
module irq_src_store
  import cpu_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int IDX_W = 5,
  parameter int VEC_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  prio_t                      wr_prio,
  input  logic [VEC_W-1:0]           wr_vec,
  input  logic                       wr_level,
  output prio_t [NSRC-1:0]           prio_o,
  output logic [NSRC-1:0][VEC_W-1:0] vec_o,
  output logic [NSRC-1:0]            level_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_o[g]  <= '0;
        vec_o[g]   <= '0;
        level_o[g] <= 1'b0;
      end else if (hit) begin
        prio_o[g]  <= wr_prio;
        vec_o[g]   <= wr_vec;
        level_o[g] <= wr_level;
      end
    end
  end
endmodule

// File: rtl/irq_rsp_slot.sv
module irq_rsp_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         can_load,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign can_load = !out_valid || out_ready;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R12
endmodule

// File: rtl/cpu_irq_ack_unit.sv
module cpu_irq_ack_unit
  import cpu_irq_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int VEC_W = 8,
  parameter int CPU_ID = 0,
  parameter int unsigned SPUR_VEC = 255,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise_valid,
  output logic              raise_ready,
  input  logic [IDX_W-1:0]  raise_idx,
  input  logic [3:0]        raise_prio,
  input  logic [VEC_W-1:0]  raise_vec,
  input  logic              raise_level,
  input  logic [NSRC-1:0]   level_drop,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_sel,
  input  logic [VEC_W-1:0]  req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [VEC_W-1:0]  rsp_data,
  output logic              irq_out
);
  localparam logic [VEC_W-1:0] SPUR = VEC_W'(SPUR_VEC);
  localparam logic [VEC_W-1:0] IDENT = VEC_W'(CPU_ID);

  prio_t            tpri_q;
  logic [NSRC-1:0]  raised_q, raised_d;
  logic [NSRC-1:0]  insv_q, insv_d;
  logic [NSRC-1:0]  active_q, active_d;
  logic             irq_q, irq_d;

  prio_t [NSRC-1:0]           src_prio;
  logic [NSRC-1:0][VEC_W-1:0] src_vec;
  logic [NSRC-1:0]            src_level;

  // Handshakes and decode
  logic req_fire, raise_fire, in_range, raise_keep;
  logic ack_fire, eoi_fire, tpri_wr, rd_fire;
  reg_sel_e sel;

  assign sel        = reg_sel_e'(req_sel);
  assign req_fire   = req_valid && req_ready;
  assign raise_ready = !req_fire;
  assign raise_fire = raise_valid && raise_ready;
  assign in_range   = int'(raise_idx) < NSRC;
  assign raise_keep = raise_fire && in_range && (raise_prio > tpri_q) && !raised_q[raise_idx];
  assign rd_fire    = req_fire && !req_write;
  assign ack_fire   = rd_fire && (sel == SEL_ACK);
  assign eoi_fire   = req_fire && req_write && (sel == SEL_EOI);
  assign tpri_wr    = req_fire && req_write && (sel == SEL_TPRI);

  // Per-source attributes, captured when a raise is kept
  irq_src_store #(.NSRC(NSRC), .IDX_W(IDX_W), .VEC_W(VEC_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (raise_keep),
    .wr_idx  (raise_idx),
    .wr_prio (raise_prio),
    .wr_vec  (raise_vec),
    .wr_level(raise_level),
    .prio_o  (src_prio),
    .vec_o   (src_vec),
    .level_o (src_level)
  );

  // Priority scans: raised set, in-service set, in-service set minus its top
  logic             r_found, s_found, s2_found;
  logic [IDX_W-1:0] r_idx, s_idx, s2_idx;
  prio_t            r_prio, s_prio, s2_prio;
  logic [NSRC-1:0]  s_onehot, insv_rest;

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_raised (
    .member(raised_q), .prio(src_prio), .found(r_found), .idx(r_idx), .best(r_prio)
  );

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_insv (
    .member(insv_q), .prio(src_prio), .found(s_found), .idx(s_idx), .best(s_prio)
  );

  assign s_onehot  = s_found ? (NSRC'(1) << s_idx) : '0;
  assign insv_rest = insv_q & ~s_onehot;

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_rest (
    .member(insv_rest), .prio(src_prio), .found(s2_found), .idx(s2_idx), .best(s2_prio)
  );

  // Acknowledge and end-of-interrupt decisions
  logic             ack_take, eoi_rearm;
  logic [VEC_W-1:0] ack_vec;

  assign ack_take  = r_found && active_q[r_idx] && (r_prio > tpri_q);
  assign ack_vec   = ack_take ? src_vec[r_idx] : SPUR;
  assign eoi_rearm = r_found && (!s2_found || (r_prio > s2_prio));

  always_comb begin
    raised_d = raised_q;
    insv_d   = insv_q;
    active_d = active_q & ~level_drop;
    irq_d    = irq_q;
    if (raise_keep) begin
      raised_d[raise_idx] = 1'b1;
      active_d[raise_idx] = 1'b1;
      irq_d = 1'b1;
    end
    if (ack_fire) begin
      irq_d = 1'b0;
      if (r_found) begin
        raised_d[r_idx] = 1'b0;
        if (ack_take) insv_d[r_idx] = 1'b1;
        else active_d[r_idx] = 1'b0;
        if (!src_level[r_idx]) active_d[r_idx] = 1'b0;
      end
    end
    if (eoi_fire) begin
      insv_d = insv_rest;
      if (eoi_rearm) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q <= '0;
      insv_q   <= '0;
      active_q <= '0;
      irq_q    <= 1'b0;
      tpri_q   <= TPRI_RESET;
    end else begin
      raised_q <= raised_d;
      insv_q   <= insv_d;
      active_q <= active_d;
      irq_q    <= irq_d;
      if (tpri_wr) tpri_q <= req_wdata[PRIO_W-1:0];
    end
  end

  assign irq_out = irq_q;

  // Read data path
  logic [VEC_W-1:0] rd_data;
  always_comb begin
    unique case (sel)
      SEL_TPRI:  rd_data = VEC_W'(tpri_q);
      SEL_IDENT: rd_data = IDENT;
      SEL_ACK:   rd_data = ack_vec;
      default:   rd_data = '0;
    endcase
  end

  irq_rsp_slot #(.W(VEC_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rd_fire),
    .load_data(rd_data),
    .can_load (req_ready),
    .out_valid(rsp_valid),
    .out_ready(rsp_ready),
    .out_data (rsp_data)
  );

  // Checks next to the logic they guard
  AST_LOW_PRIO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fire && (raise_prio <= tpri_q) |=> $stable(raised_q)); // R1
  AST_DUP_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fire && in_range && raised_q[raise_idx] |=> $stable(raised_q) && $stable(irq_out)); // R2
  AST_KEEP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fire && in_range && (raise_prio > tpri_q) && !raised_q[raise_idx] |=> irq_out); // R11
  AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_out); // R4
  AST_ACK_EMPTY_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && !r_found |=> rsp_valid && (rsp_data == SPUR)); // R4
  AST_ACK_POPS: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && r_found |=> !raised_q[$past(r_idx)]); // R6
  AST_EDGE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire && r_found && !src_level[r_idx] |=> !active_q[$past(r_idx)]); // R6
  AST_EOI_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire && s_found |=> $countones(insv_q) == $countones($past(insv_q)) - 1); // R7
  AST_RAISE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |-> !raise_ready); // R12
endmodule

// File: tb/cpu_irq_ack_unit_bench.sv
`timescale 1ns/1ps
module cpu_irq_ack_unit_bench;
  localparam int NSRC = 12;
  localparam int VEC_W = 8;
  localparam int CPU_ID = 5;
  localparam int SPUR = 8'h3C;
  localparam int IDX_W = $clog2(NSRC);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             raise_valid = 0, raise_level = 0;
  logic             raise_ready;
  logic [IDX_W-1:0] raise_idx = '0;
  logic [3:0]       raise_prio = '0;
  logic [VEC_W-1:0] raise_vec = '0;
  logic [NSRC-1:0]  level_drop = '0;
  logic             req_valid = 0, req_write = 0, rsp_ready = 1;
  logic             req_ready, rsp_valid, irq_out;
  logic [1:0]       req_sel = '0;
  logic [VEC_W-1:0] req_wdata = '0, rsp_data;

  cpu_irq_ack_unit #(.NSRC(NSRC), .VEC_W(VEC_W), .CPU_ID(CPU_ID), .SPUR_VEC(SPUR)) u_cpu_irq_ack_unit (
    .clk(clk), .rst_n(rst_n),
    .raise_valid(raise_valid), .raise_ready(raise_ready), .raise_idx(raise_idx),
    .raise_prio(raise_prio), .raise_vec(raise_vec), .raise_level(raise_level),
    .level_drop(level_drop),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_sel(req_sel), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq_out(irq_out)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Reference state
  logic [NSRC-1:0] m_raised = '0, m_insv = '0, m_active = '0;
  int m_prio [NSRC];
  int m_vec [NSRC];
  bit m_lvl [NSRC];
  int m_tpri = 15;
  bit m_irq = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pick(logic [NSRC-1:0] s);
    int b = -1;
    for (int i = 0; i < NSRC; i++)
      if (s[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
    return b;
  endfunction

  task automatic do_raise(string tag, int idx, int p, int v, bit lvl);
    @(negedge clk);
    raise_valid = 1; raise_idx = IDX_W'(idx); raise_prio = 4'(p);
    raise_vec = VEC_W'(v); raise_level = lvl;
    @(posedge clk); #1 raise_valid = 0;
    if (p > m_tpri && !m_raised[idx]) begin
      m_raised[idx] = 1; m_active[idx] = 1;
      m_prio[idx] = p; m_vec[idx] = v; m_lvl[idx] = lvl; m_irq = 1;
    end
    @(negedge clk);
    check(tag, irq_out, m_irq);
  endtask

  task automatic reg_read(int sel, output int data);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_sel = 2'(sel);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    check("R12 rsp_valid after read", rsp_valid, 1);
    data = rsp_data;
  endtask

  task automatic reg_write(int sel, int data);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_sel = 2'(sel); req_wdata = VEC_W'(data);
    @(posedge clk); #1 req_valid = 0; req_write = 0;
    @(negedge clk);
  endtask

  task automatic do_ack(string tag);
    int r, exp, d;
    r = pick(m_raised);
    exp = SPUR;
    if (r >= 0) begin
      if (m_active[r] && m_prio[r] > m_tpri) begin
        m_insv[r] = 1; exp = m_vec[r];
      end else m_active[r] = 0;
      m_raised[r] = 0;
      if (!m_lvl[r]) m_active[r] = 0;
    end
    m_irq = 0;
    reg_read(2, d);
    check(tag, d, exp);
    check({tag, " irq low (R4)"}, irq_out, m_irq);
  endtask

  task automatic do_eoi(string tag, int wd);
    int s, s2, r, d;
    s = pick(m_insv);
    if (s >= 0) m_insv[s] = 0;
    s2 = pick(m_insv);
    r = pick(m_raised);
    if (r >= 0 && (s2 < 0 || m_prio[r] > m_prio[s2])) m_irq = 1;
    reg_write(3, wd);
    check(tag, irq_out, m_irq);
  endtask

  task automatic do_tpri(int v);
    int d;
    reg_write(0, v);
    m_tpri = v & 15;
    reg_read(0, d);
    check("R9 task priority low bits", d, m_tpri);
  endtask

  task automatic do_drop(logic [NSRC-1:0] msk);
    @(negedge clk);
    level_drop = msk;
    @(posedge clk); #1 level_drop = '0;
    m_active = m_active & ~msk;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int d;
    for (int i = 0; i < NSRC; i++) begin m_prio[i] = 0; m_vec[i] = 0; m_lvl[i] = 0; end
    void'($urandom(32'd20231));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // Reset state
    check("R9 reset irq_out", irq_out, 0);
    check("R9 reset rsp_valid", rsp_valid, 0);
    check("R12 reset req_ready", req_ready, 1);
    reg_read(0, d); check("R9 reset task priority", d, 15);
    do_ack("R4 empty ack spurious");

    // Dropped at task priority 15
    do_raise("R1 raise at tpri dropped", 3, 15, 8'h33, 0);
    do_ack("R1 dropped raise not queued");

    // Task priority keeps low bits
    reg_write(0, 8'h3A); reg_read(0, d); check("R9 low nibble kept", d, 8'h0A);
    m_tpri = 10;
    do_tpri(2);
    do_raise("R1 equal priority dropped", 1, 2, 8'h11, 0);

    // Tie and ordering
    do_raise("R11 raise sets irq", 7, 9, 8'h70, 0);
    do_raise("R11 raise tie", 4, 9, 8'h40, 0);
    do_raise("R11 raise lower", 9, 6, 8'h90, 0);
    do_ack("R3 tie lowest index");
    do_ack("R3 second of tie");
    do_ack("R3 lower priority last");
    do_ack("R4 empty after drain");
    reg_read(3, d); check("R7 eoi reads zero", d, 0);
    do_eoi("R7 eoi retires top", 8'hFF);
    do_eoi("R7 eoi retires next", 8'h00);
    do_eoi("R7 eoi retires last", 8'h5A);

    // Missed interrupt
    do_raise("R11 raise 5", 5, 7, 8'h55, 0);
    do_raise("R2 duplicate raise ignored", 5, 12, 8'h99, 1);
    do_ack("R2 original vector kept");
    do_eoi("R7 eoi clean", 0);

    // Stale by task priority
    do_raise("R11 raise 2", 2, 4, 8'h22, 0);
    do_tpri(6);
    do_ack("R5 outranked by task priority spurious");
    do_tpri(2);

    // Activity dropped
    do_raise("R11 raise level 6", 6, 8, 8'h66, 1);
    do_drop(NSRC'(1) << 6);
    do_ack("R13 dropped activity spurious");
    do_raise("R11 raise level 6 again", 6, 8, 8'h67, 1);
    do_ack("R5 level source serviced");
    do_eoi("R8 eoi no raised", 0);

    // EOI re-raise ordering
    do_raise("R11 raise A", 1, 9, 8'hA1, 0);
    do_raise("R11 raise B", 8, 3, 8'hB8, 0);
    do_ack("R5 A serviced");
    do_raise("R11 raise C", 3, 12, 8'hC3, 0);
    do_ack("R5 C serviced");
    do_eoi("R8 no rearm below in-service", 8'h11);
    check("R8 irq stays low", irq_out, 0);
    do_eoi("R8 rearm when service empty", 8'h22);
    check("R8 irq raised again", irq_out, 1);
    do_ack("R6 B acknowledged");
    do_ack("R6 B removed from raised");
    do_eoi("R7 eoi B", 0);

    // Identity and ignored writes
    reg_read(1, d); check("R10 identity", d, CPU_ID);
    do_raise("R11 raise 10", 10, 5, 8'hAA, 0);
    reg_write(1, 8'h77);
    reg_write(2, 8'h12);
    check("R10 writes leave irq", irq_out, m_irq);
    reg_read(1, d); check("R10 identity after write", d, CPU_ID);
    reg_read(0, d); check("R10 task priority unchanged", d, m_tpri);
    do_ack("R10 raised set unchanged");
    do_eoi("R7 eoi 10", 0);

    // Back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_write = 0; req_sel = 2'(1);
    #0.5 check("R12 raise refused while request taken", raise_ready, 0);
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    check("R12 rsp valid held", rsp_valid, 1);
    check("R12 req_ready low when full", req_ready, 0);
    @(negedge clk);
    check("R12 rsp still valid", rsp_valid, 1);
    check("R12 rsp data stable", rsp_data, CPU_ID);
    check("R12 raise_ready while blocked", raise_ready, 1);
    rsp_ready = 1;
    #0.5 check("R12 req_ready with rsp_ready", req_ready, 1);
    @(negedge clk);
    check("R12 slot drained", rsp_valid, 0);

    // Random phase
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2, 3: do_raise("R1/R2/R11 random raise", $urandom_range(0, NSRC - 1),
                             $urandom_range(0, 15), $urandom_range(0, 255), 1'($urandom_range(0, 1)));
        4, 5: do_ack("R3/R5/R6 random ack");
        6: do_eoi("R7/R8 random eoi", $urandom_range(0, 255));
        7: do_tpri(($urandom_range(0, 15) << 4) | $urandom_range(0, 7));
        8: do_drop(NSRC'(1) << $urandom_range(0, NSRC - 1));
        default: begin reg_read(1, d); check("R10 random identity", d, CPU_ID); end
      endcase
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule